// File: doc/BRIEF.md
# Stream Byte and Frame Statistics Monitor

The block sits beside a valid/ready stream link and watches it. It never drives the link. On every cycle in which a beat transfers, it adds the number of set keep bits to a running byte total. When that beat also closes a frame, it adds one to a running frame total.

A pulse on the trigger input captures both totals together with a caller-supplied tag, then clears the totals. The captured values leave the block as one short byte-wide frame on a separate report stream that has its own backpressure.

Several monitors can share one trigger. A downstream joiner can then concatenate their reports, so each report is a complete, self-contained frame with a fixed length.

Top module: `stream_stat_mon`

## Requirements
- R1: On each cycle with `mon_valid_i` and `mon_ready_i` both high, the byte total grows by the number of ones in `mon_keep_i`. Without that handshake, the byte total does not change.
- R2: On each handshake cycle with `mon_last_i` high, the frame total grows by one.
- R3: A trigger accepted while no report is pending captures the totals, including any beat that transfers in the trigger cycle. The totals then restart from zero on the next cycle. `rpt_valid_o` rises in the cycle after the trigger.
- R4: A report is (TAG_W+BCNT_W+FCNT_W)/8 bytes long. Each field is sent most significant byte first, in the order tag, byte total, frame total. Every width is a multiple of 8.
- R5: `rpt_last_o` is high only while the final report byte is presented. `rpt_valid_o` drops in the cycle after that byte is accepted. `rpt_user_o` is always low.
- R6: While `rpt_valid_o` is high and `rpt_ready_i` is low, `rpt_valid_o`, `rpt_data_o` and `rpt_last_o` hold their values.
- R7: A trigger that arrives while a report is still pending is ignored. It does not clear the totals and does not change the report in flight. Traffic in that cycle still counts toward the next report.
- R8: After reset, no report is pending and both totals are zero.
- R9: Both totals wrap modulo 2^BCNT_W and 2^FCNT_W respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mon_keep_i | input | KEEP_W | Keep bits of the watched link, one per byte lane |
| mon_valid_i | input | 1 | Valid of the watched link |
| mon_ready_i | input | 1 | Ready of the watched link (observed only) |
| mon_last_i | input | 1 | End-of-frame marker of the watched link |
| trig_i | input | 1 | Capture-and-clear request |
| tag_i | input | TAG_W | Tag placed at the head of the report |
| rpt_data_o | output | 8 | Report byte |
| rpt_valid_o | output | 1 | Report byte valid |
| rpt_ready_i | input | 1 | Report sink ready |
| rpt_last_o | output | 1 | Final report byte |
| rpt_user_o | output | 1 | Bad-frame flag, always low |

## Verification
A wrong running total shows up only in the next report, in the byte-total or frame-total field of the report that follows the faulty traffic. The bench therefore reads a report after every keep pattern it sweeps, so a count error is localised to within a handful of cycles. A broken clear shows as residue carried into the following report. A corrupt byte index or shift register shows at once as a misplaced `rpt_last_o`, a wrong report length, or a byte that changes under backpressure.

// File: rtl/stat_mon_pkg.sv
package stat_mon_pkg;
  typedef enum logic {TX_IDLE, TX_SEND} tx_state_e;

  function automatic int report_len(int tag_w, int bcnt_w, int fcnt_w);
    return (tag_w + bcnt_w + fcnt_w) / 8;
  endfunction
endpackage

// File: rtl/stat_keep_count.sv
module stat_keep_count #(
  parameter int KEEP_W = 4,
  localparam int CNT_W = $clog2(KEEP_W + 1)
) (
  input  logic [KEEP_W-1:0] keep_i,
  output logic [CNT_W-1:0]  cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < KEEP_W; i++) cnt_o = cnt_o + CNT_W'(keep_i[i]);
  end
endmodule

// File: rtl/stat_counter.sv
module stat_counter #(
  parameter int CNT_W = 16,
  parameter int INC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [INC_W-1:0] inc_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] next_o
);
  logic [CNT_W-1:0] cnt_q;

  // next_o includes this cycle's increment so a snapshot taken now sees it
  assign next_o = cnt_q + CNT_W'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else              cnt_q <= next_o;
  end
endmodule

// File: rtl/stat_report_tx.sv
module stat_report_tx
  import stat_mon_pkg::*;
#(
  parameter int PAY_W = 40,
  localparam int NBYTES = PAY_W / 8,
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PAY_W-1:0] payload_i,
  output logic             busy_o,
  output logic [7:0]       data_o,
  output logic             valid_o,
  input  logic             ready_i,
  output logic             last_o,
  output logic             user_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

  tx_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic [PAY_W-1:0] shreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      idx_q   <= '0;
      shreg_q <= '0;
    end else begin
      unique case (state_q)
        TX_IDLE: if (load_i) begin
          shreg_q <= payload_i;
          idx_q   <= '0;
          state_q <= TX_SEND;
        end
        TX_SEND: if (ready_i) begin
          if (idx_q == LAST_IDX) begin
            state_q <= TX_IDLE;
          end else begin
            shreg_q <= shreg_q << 8;
            idx_q   <= idx_q + 1'b1;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign valid_o = (state_q == TX_SEND);
  assign busy_o  = valid_o;
  assign data_o  = shreg_q[PAY_W-1 -: 8];
  assign last_o  = valid_o && (idx_q == LAST_IDX);
  assign user_o  = 1'b0;
endmodule

// File: rtl/stream_stat_mon.sv
module stream_stat_mon
  import stat_mon_pkg::*;
#(
  parameter int KEEP_W = 4,
  parameter int TAG_W  = 8,
  parameter int BCNT_W = 16,
  parameter int FCNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [KEEP_W-1:0] mon_keep_i,
  input  logic              mon_valid_i,
  input  logic              mon_ready_i,
  input  logic              mon_last_i,
  input  logic              trig_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic [7:0]        rpt_data_o,
  output logic              rpt_valid_o,
  input  logic              rpt_ready_i,
  output logic              rpt_last_o,
  output logic              rpt_user_o
);
  localparam int KC_W  = $clog2(KEEP_W + 1);
  localparam int PAY_W = report_len(TAG_W, BCNT_W, FCNT_W) * 8;

  logic              xfer, snap, busy;
  logic [KC_W-1:0]   keep_cnt, byte_inc;
  logic [0:0]        frame_inc;
  logic [BCNT_W-1:0] bcnt_next;
  logic [FCNT_W-1:0] fcnt_next;

  assign xfer      = mon_valid_i && mon_ready_i;
  assign byte_inc  = xfer ? keep_cnt : '0;
  assign frame_inc = xfer && mon_last_i;
  assign snap      = trig_i && !busy;

  stat_keep_count #(.KEEP_W(KEEP_W)) u_keep (
    .keep_i (mon_keep_i),
    .cnt_o  (keep_cnt)
  );

  stat_counter #(.CNT_W(BCNT_W), .INC_W(KC_W)) u_bcnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (byte_inc),
    .clear_i (snap),
    .next_o  (bcnt_next)
  );

  stat_counter #(.CNT_W(FCNT_W), .INC_W(1)) u_fcnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (frame_inc),
    .clear_i (snap),
    .next_o  (fcnt_next)
  );

  stat_report_tx #(.PAY_W(PAY_W)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (snap),
    .payload_i ({tag_i, bcnt_next, fcnt_next}),
    .busy_o    (busy),
    .data_o    (rpt_data_o),
    .valid_o   (rpt_valid_o),
    .ready_i   (rpt_ready_i),
    .last_o    (rpt_last_o),
    .user_o    (rpt_user_o)
  );
endmodule

// File: rtl/stat_mon_chk.sv
module stat_mon_chk #(
  parameter int TAG_W  = 8,
  parameter int BCNT_W = 16,
  parameter int FCNT_W = 16,
  localparam int LEN   = (TAG_W + BCNT_W + FCNT_W) / 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       trig_i,
  input logic [7:0] rpt_data_o,
  input logic       rpt_valid_o,
  input logic       rpt_ready_i,
  input logic       rpt_last_o,
  input logic       rpt_user_o
);
  logic [15:0] beat_q;
  logic        fire;

  assign fire = rpt_valid_o && rpt_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          beat_q <= '0;
    else if (fire)        beat_q <= rpt_last_o ? 16'd0 : beat_q + 16'd1;
  end

  a_r4_last_position: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && rpt_last_o) |-> (beat_q == 16'(LEN - 1)));
  a_r4_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && beat_q == 16'(LEN - 1)) |-> rpt_last_o);
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_valid_o && !rpt_ready_i) |=> (rpt_valid_o && $stable(rpt_data_o) && $stable(rpt_last_o)));
  a_r5_user_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_user_o == 1'b0);
  a_r5_last_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_last_o |-> rpt_valid_o);
  a_r5_end_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && rpt_last_o) |=> !rpt_valid_o);
  a_r3_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && !rpt_valid_o) |=> (rpt_valid_o && beat_q == 16'd0));
  a_r7_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && rpt_valid_o && !rpt_ready_i) |=> (rpt_valid_o && $stable(rpt_data_o)));
endmodule

bind stream_stat_mon stat_mon_chk #(
  .TAG_W(TAG_W), .BCNT_W(BCNT_W), .FCNT_W(FCNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .trig_i      (trig_i),
  .rpt_data_o  (rpt_data_o),
  .rpt_valid_o (rpt_valid_o),
  .rpt_ready_i (rpt_ready_i),
  .rpt_last_o  (rpt_last_o),
  .rpt_user_o  (rpt_user_o)
);

// File: tb/sim_stream_stat_mon.sv
module sim_stream_stat_mon;
  localparam int KW = 4, TW = 8, BW = 16, FW = 16;
  localparam int PW = TW + BW + FW, LEN = PW / 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [KW-1:0] mon_keep = '0;
  logic mon_valid = 0, mon_ready = 0, mon_last = 0, trig = 0, rpt_ready = 0;
  logic [TW-1:0] tag = '0;
  logic [7:0] rpt_data;
  logic rpt_valid, rpt_last, rpt_user;

  stream_stat_mon #(.KEEP_W(KW), .TAG_W(TW), .BCNT_W(BW), .FCNT_W(FW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mon_keep_i(mon_keep), .mon_valid_i(mon_valid),
    .mon_ready_i(mon_ready), .mon_last_i(mon_last), .trig_i(trig), .tag_i(tag),
    .rpt_data_o(rpt_data), .rpt_valid_o(rpt_valid), .rpt_ready_i(rpt_ready),
    .rpt_last_o(rpt_last), .rpt_user_o(rpt_user));

  int checks = 0, fails = 0;
  logic [BW-1:0] exp_b = '0;
  logic [FW-1:0] exp_f = '0;
  logic [PW-1:0] exp_rpt;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic beat(logic [KW-1:0] k, logic v, logic r, logic l);
    @(negedge clk);
    mon_keep = k; mon_valid = v; mon_ready = r; mon_last = l;
    @(posedge clk);
    if (v && r) begin
      exp_b += BW'($countones(k));
      if (l) exp_f += 1'b1;
    end
  endtask

  // trigger (with optional same-cycle beat), then read the report
  task automatic report(logic [TW-1:0] t, logic [KW-1:0] ck, logic cv, logic cl,
                        int stall, int inj_at);
    int i, cyc;
    bit done_inj, inj, rdy;
    @(negedge clk);
    trig = 1; tag = t; mon_keep = ck; mon_valid = cv; mon_ready = 1; mon_last = cl;
    @(posedge clk);
    if (cv) begin
      exp_b += BW'($countones(ck));
      if (cl) exp_f += 1'b1;
    end
    exp_rpt = {t, exp_b, exp_f};
    exp_b = '0; exp_f = '0;
    @(negedge clk);
    trig = 0; mon_valid = 0; mon_last = 0;
    i = 0; cyc = 0; done_inj = 0;
    while (i < LEN) begin
      rdy = (stall == 0) || ((cyc % (stall + 1)) != 0);
      rpt_ready = rdy;
      inj = (i == inj_at) && !done_inj;
      if (inj) begin
        done_inj = 1;
        trig = 1; tag = ~t; mon_valid = 1; mon_keep = 4'b0111; mon_last = 1;
      end
      chk("R6 valid held while pending", 64'(rpt_valid), 64'd1);
      chk("R4 report byte", 64'(rpt_data), 64'(exp_rpt[PW-1-8*i -: 8]));
      chk("R5 last position", 64'(rpt_last), 64'(i == LEN - 1));
      chk("R5 user low", 64'(rpt_user), 64'd0);
      @(posedge clk);
      if (inj) begin exp_b += BW'(3); exp_f += 1'b1; end // R7: counted, not cleared
      if (rdy) i++;
      cyc++;
      @(negedge clk);
      trig = 0; mon_valid = 0; mon_last = 0; rpt_ready = 0;
    end
    chk("R5 valid drops after final byte", 64'(rpt_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset valid", 64'(rpt_valid), 64'd0);
    chk("R8 reset last", 64'(rpt_last), 64'd0);
    rst_ni = 1;
    report(8'hA5, '0, 0, 0, 0, -1);               // R8: zero totals after reset
    // R1/R2 sweep of every keep pattern and handshake combination
    for (int k = 0; k < 16; k++) begin
      for (int vr = 0; vr < 4; vr++)
        beat(KW'(k), vr[0], vr[1], (k % 3) == 0 || vr == 3);
      report(8'(k * 17 + 3), KW'(15 - k), k[0], k[1], k % 4, -1);  // R3 same-cycle beat
    end
    // R7: trigger mid-report is ignored, its beat counts into the next report
    beat(4'b1111, 1, 1, 0);
    report(8'h3C, 4'b0001, 1, 1, 1, 2);
    report(8'h4D, '0, 0, 0, 0, LEN - 1);            // R7 at final byte
    report(8'h5E, '0, 0, 0, 0, -1);
    // R9: wrap of both totals
    for (int n = 0; n < 65540; n++) beat(4'b1111, 1, 1, 1);
    report(8'h77, '0, 0, 0, 2, -1);
    chk("R9 wrapped byte total", 64'(exp_rpt[FW +: BW]), 64'd16);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule